// File: doc/BRIEF.md
# HDLC Frame Transmitter with Programmable Interframe Fill

This block turns frames read from a byte-wide transmit queue into a serial HDLC line. In standard mode it wraps each frame in flag bytes (0x7E), inserts a zero after every run of five ones inside the frame body and the check sequence, and appends a 16-bit FCS. The FCS is either computed by the block or supplied by software as the final two queue bytes. Between frames and while nothing is queued it sends fill bytes. Both the number of fill bytes between frames and their value are set by configuration inputs. One fill setting lets a closing flag double as the next frame's opening flag.

The queue side is a valid/ready read port with an end-of-frame marker, plus a one-cycle flush strobe. An abort input stops the frame in flight with a run of seven ones and empties the queue. An initialize input restarts the transmitter and latches the mode and FCS-control settings. A transparent mode sends queue bytes unchanged, with no framing. The line side is a data bit and a one-cycle strobe that marks each new bit. A new bit is produced every `CLK_PER_BIT` clocks.

Top module: `hdlc_fill_tx`

## Requirements
- R1: Every byte goes out least-significant bit first. A standard-mode frame is an opening flag 0x7E, the frame bytes, the FCS and a closing flag 0x7E.
- R2: In standard mode a 0 is inserted after any five consecutive 1s in frame bytes and FCS, including runs that cross byte boundaries and runs that end just before the closing flag. Flags, fill bytes and the abort byte are never stuffed.
- R3: With automatic FCS, the FCS is the reflected CRC-16 with polynomial x^16+x^12+x^5+1 (0x8408 in reflected form), preset to 0xFFFF and complemented. It is sent low byte first. For the bytes "123456789" this gives low byte 0x6E, then 0x90.
- R4: With fill count N from 1 to 7, exactly N-1 fill bytes lie between a closing flag and the next opening flag when the next frame is already queued. N=1 puts two adjacent flags; N=7 puts six fill bytes.
- R5: Fill count 0 with the priority-disable input at 1 makes the closing flag also the opening flag of an already-queued next frame. With priority-disable at 0, fill count 0 behaves like 1.
- R6: The fill and idle byte is 0x7E only when the idle-select input is 0 and priority-disable is 1; otherwise it is 0xFF.
- R7: An abort request sets `abort_pend`, which clears when the abort is acted on. A frame in flight is then cut short with the unstuffed byte 0x7F (seven ones) followed by fill, with no closing flag, and `fifo_flush` pulses so the queue is emptied.
- R8: In transparent mode queue bytes go out unchanged (no flags, stuffing or FCS), and idle bytes fill gaps. A change of the mode input only takes effect at the end of an initialization.
- R9: With manual FCS, no FCS is generated; the frame bytes, including the software FCS, are stuffed and followed by the closing flag. The setting takes effect only at the end of an initialization.
- R10: `init_busy` is 1 during reset and for `INIT_CYCLES` clocks after reset or after an `init_req` pulse. Meanwhile the line holds 1, no strobe is produced and no queue byte is read.
- R11: If the queue runs empty in the middle of a standard-mode frame, the frame is ended with the 0x7F abort byte and fill, without flushing the queue.
- R12: Outside initialization `tx_stb` pulses exactly once every `CLK_PER_BIT` clocks, and `tx_bit` holds the new bit while the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, starts an initialization |
| fifo_data | input | 8 | Head byte of the transmit queue |
| fifo_valid | input | 1 | Queue holds a byte |
| fifo_last | input | 1 | Head byte ends its frame |
| fifo_ready | output | 1 | Head byte is consumed this clock when valid |
| fifo_flush | output | 1 | One-clock request to empty the queue |
| cfg_fill_cnt | input | 3 | Interframe spacing code |
| cfg_idle_ones | input | 1 | 1 selects all-ones fill, 0 selects flag fill |
| cfg_prio_off | input | 1 | Priority-disable; permits flag fill and shared flags |
| cfg_transparent | input | 1 | 1 selects transparent mode (latched at init) |
| cfg_manual_fcs | input | 1 | 1 selects software-supplied FCS (latched at init) |
| abort_req | input | 1 | Pulse to abort the current frame |
| abort_pend | output | 1 | Abort requested and not yet acted on |
| init_req | input | 1 | Pulse to restart the transmitter |
| init_busy | output | 1 | Initialization in progress |
| tx_bit | output | 1 | Serial line data |
| tx_stb | output | 1 | Marks a new bit on tx_bit |

## Verification
The framing path is tried with several byte patterns. A known ASCII string pins the FCS to an independent bitwise CRC and a fixed value. A byte pair with a ten-one run across its boundary, plus an all-ones byte and a flag-valued byte inside a frame, separates correct stuffing from per-byte or missing stuffing. Pairs of queued frames under fill codes 7, 1 and 0, with priority-disable both low and high, tell apart the fill arithmetic, the shared-flag path and its gating. Further patterns cover the fill value: all-zero frames that are aborted mid-way, an open frame that runs the queue dry, transparent and manual-FCS frames, and a mode change without initialization. These tell apart the abort byte, the flush, the mode latching and the FCS source.

// File: rtl/hdlc_fill_tx.sv
module hdlc_fill_tx #(
  parameter int CLK_PER_BIT = 4,
  parameter int INIT_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] fifo_data,
  input  logic       fifo_valid,
  input  logic       fifo_last,
  output logic       fifo_ready,
  output logic       fifo_flush,
  input  logic [2:0] cfg_fill_cnt,
  input  logic       cfg_idle_ones,
  input  logic       cfg_prio_off,
  input  logic       cfg_transparent,
  input  logic       cfg_manual_fcs,
  input  logic       abort_req,
  output logic       abort_pend,
  input  logic       init_req,
  output logic       init_busy,
  output logic       tx_bit,
  output logic       tx_stb
);
  localparam int DW = (CLK_PER_BIT > 2) ? $clog2(CLK_PER_BIT) : 1;
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam logic [7:0] FLAG = 8'h7E;
  localparam logic [7:0] ABRT = 8'h7F;

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_DATA, S_FCS1, S_FCS2, S_CLOSE, S_FILL} st_t;

  st_t         st, nst;
  logic [7:0]  sh, nb;
  logic [3:0]  bcnt;
  logic [2:0]  ones, fcnt, eff;
  logic [DW-1:0] div;
  logic [IW-1:0] icnt;
  logic [15:0] crc;
  logic        stuff_q, mode_q, man_q, shared_q;
  logic        tick, ld, ns, crc_set, crc_upd, sh_set, fill_ld, in_frame;
  logic [7:0]  idle_byte;

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  assign init_busy = (st == S_INIT);
  assign tick      = !init_busy && (div == DW'(CLK_PER_BIT - 1));
  assign ld        = !init_busy && (bcnt == 4'd0) && (ones != 3'd5) && !tick;
  assign idle_byte = (cfg_prio_off && !cfg_idle_ones) ? FLAG : 8'hFF;
  assign eff       = (cfg_fill_cnt == 3'd0 && !cfg_prio_off) ? 3'd1 : cfg_fill_cnt;
  assign in_frame  = (st == S_DATA) || (st == S_FCS1) || (st == S_FCS2);
  assign fifo_ready = ld && !abort_pend &&
                      ((st == S_DATA) || ((st == S_IDLE) && (mode_q || shared_q)));
  assign fifo_flush = ld && abort_pend;

  always_comb begin
    nb = idle_byte; ns = 1'b0; nst = st;
    crc_set = 1'b0; crc_upd = 1'b0; sh_set = 1'b0; fill_ld = 1'b0;
    if (in_frame && (abort_pend || (st == S_DATA && !fifo_valid))) begin
      nb = ABRT; nst = S_IDLE; crc_set = 1'b1;
    end else begin
      case (st)
        S_IDLE: begin
          if (abort_pend || !fifo_valid) nb = idle_byte;
          else if (mode_q) nb = fifo_data;
          else if (shared_q) begin
            nb = fifo_data; ns = 1'b1; crc_upd = 1'b1;
            nst = fifo_last ? (man_q ? S_CLOSE : S_FCS1) : S_DATA;
          end else begin
            nb = FLAG; nst = S_DATA; crc_set = 1'b1;
          end
        end
        S_DATA: begin
          nb = fifo_data; ns = 1'b1; crc_upd = 1'b1;
          nst = fifo_last ? (man_q ? S_CLOSE : S_FCS1) : S_DATA;
        end
        S_FCS1: begin nb = ~crc[7:0];  ns = 1'b1; nst = S_FCS2;  end
        S_FCS2: begin nb = ~crc[15:8]; ns = 1'b1; nst = S_CLOSE; end
        S_CLOSE: begin
          nb = FLAG; crc_set = 1'b1; nst = S_IDLE;
          if (eff == 3'd0) sh_set = 1'b1;
          else if (eff != 3'd1) begin nst = S_FILL; fill_ld = 1'b1; end
        end
        S_FILL: begin
          nb = idle_byte;
          if (fcnt == 3'd1) nst = S_IDLE;
        end
        default: nst = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_INIT; icnt <= '0; div <= '0; sh <= 8'hFF; bcnt <= '0; ones <= '0;
      fcnt <= '0; crc <= 16'hFFFF; stuff_q <= 1'b0; mode_q <= 1'b0; man_q <= 1'b0;
      shared_q <= 1'b0; abort_pend <= 1'b0; tx_bit <= 1'b1; tx_stb <= 1'b0;
    end else if (init_req) begin
      st <= S_INIT; icnt <= '0; div <= '0; bcnt <= '0; ones <= '0; shared_q <= 1'b0;
      abort_pend <= 1'b0; tx_bit <= 1'b1; tx_stb <= 1'b0;
    end else if (st == S_INIT) begin
      div <= '0; tx_stb <= 1'b0;
      if (icnt == IW'(INIT_CYCLES - 1)) begin
        st <= S_IDLE; mode_q <= cfg_transparent; man_q <= cfg_manual_fcs;
        crc <= 16'hFFFF; shared_q <= 1'b0;
      end else icnt <= icnt + 1'b1;
    end else begin
      tx_stb <= tick;
      div    <= tick ? '0 : div + 1'b1;
      if (tick) begin
        if (ones == 3'd5) begin
          tx_bit <= 1'b0; ones <= '0;
        end else if (bcnt != 4'd0) begin
          tx_bit <= sh[0]; sh <= {1'b1, sh[7:1]}; bcnt <= bcnt - 1'b1;
          ones <= (stuff_q && sh[0]) ? ones + 1'b1 : 3'd0;
        end
      end
      if (ld && abort_pend) abort_pend <= 1'b0;
      else if (abort_req) abort_pend <= 1'b1;
      if (ld) begin
        st <= nst; sh <= nb; bcnt <= 4'd8; stuff_q <= ns;
        if (!ns) ones <= '0;
        if (crc_set) crc <= 16'hFFFF;
        else if (crc_upd) crc <= crc_byte(crc, fifo_data);
        if (sh_set) shared_q <= 1'b1;
        else if (st == S_IDLE) shared_q <= 1'b0;
        if (fill_ld) fcnt <= eff - 3'd1;
        else if (st == S_FILL) fcnt <= fcnt - 3'd1;
      end
    end
  end

  // R12
  stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |=> !tx_stb);
  // R12
  tick_has_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (bcnt != 4'd0 || ones == 3'd5));
  // R2
  ones_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= 3'd5);
  // R7
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> !abort_pend);
  // R10
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> (!fifo_ready && !fifo_flush && !tick));
endmodule

// File: tb/hdlc_fill_tx_test.sv
`timescale 1ns/1ps
module hdlc_fill_tx_test;
  localparam int DIV = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] fifo_data = '0;
  logic fifo_valid = 1'b0, fifo_last = 1'b0;
  logic fifo_ready, fifo_flush, abort_pend, init_busy, tx_bit, tx_stb;
  logic [2:0] cfg_fill_cnt = 3'd1;
  logic cfg_idle_ones = 1'b1, cfg_prio_off = 1'b0, cfg_transparent = 1'b0, cfg_manual_fcs = 1'b0;
  logic abort_req = 1'b0, init_req = 1'b0;
  int checks = 0, failures = 0;

  hdlc_fill_tx #(.CLK_PER_BIT(DIV), .INIT_CYCLES(4)) uut (
    .clk, .rst_n, .fifo_data, .fifo_valid, .fifo_last, .fifo_ready, .fifo_flush,
    .cfg_fill_cnt, .cfg_idle_ones, .cfg_prio_off, .cfg_transparent, .cfg_manual_fcs,
    .abort_req, .abort_pend, .init_req, .init_busy, .tx_bit, .tx_stb);

  always #4 clk = ~clk;

  logic [8:0] fq[$];
  logic pend_pop = 1'b0, pend_flush = 1'b0;
  always @(negedge clk) begin
    if (pend_flush) fq.delete();
    else if (pend_pop) void'(fq.pop_front());
    fifo_valid = fq.size() > 0;
    if (fq.size() > 0) {fifo_last, fifo_data} = fq[0];
    pend_pop = fifo_valid && fifo_ready;
    pend_flush = fifo_flush;
  end

  logic cap[$];
  always @(negedge clk) if (tx_stb) cap.push_back(tx_bit);

  logic exp_q[$];
  int e_ones;
  logic [7:0] fb[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic e_clear(); exp_q.delete(); e_ones = 0; endtask
  task automatic e_byte(input logic [7:0] b, input bit st);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back(b[i]);
      if (!st) e_ones = 0;
      else begin
        e_ones = b[i] ? e_ones + 1 : 0;
        if (e_ones == 5) begin exp_q.push_back(1'b0); e_ones = 0; end
      end
    end
  endtask

  function automatic logic [15:0] ref_crc();
    logic [15:0] c = 16'hFFFF;
    foreach (fb[k])
      for (int i = 0; i < 8; i++) begin
        logic fbk;
        fbk = c[0] ^ fb[k][i];
        c = {1'b0, c[15:1]};
        if (fbk) begin c[15] = ~c[15]; c[10] = ~c[10]; c[3] = ~c[3]; end
      end
    return ~c;
  endfunction

  task automatic e_content(input bit auto_fcs);
    logic [15:0] f;
    f = ref_crc();
    foreach (fb[k]) e_byte(fb[k], 1'b1);
    if (auto_fcs) begin e_byte(f[7:0], 1'b1); e_byte(f[15:8], 1'b1); end
  endtask

  task automatic push_fb(input bit close);
    foreach (fb[k]) fq.push_back({close && (k == fb.size() - 1), fb[k]});
  endtask

  task automatic wait_bits(input int n); repeat (n * DIV + 40) @(negedge clk); endtask

  task automatic start_cap(); @(negedge clk); cap.delete(); endtask

  task automatic cmp_stream(input string req);
    int s, bad;
    s = -1; bad = -1;
    foreach (cap[i]) if (s < 0 && cap[i] == 1'b0) s = i;
    if (s < 0 || cap.size() - s < exp_q.size()) begin
      chk(1'b0, req, "stream length", cap.size() - s, exp_q.size());
      return;
    end
    foreach (exp_q[i]) if (bad < 0 && cap[s + i] !== exp_q[i]) bad = i;
    if (bad < 0) chk(1'b1, req, "stream", 0, 0);
    else chk(1'b0, req, $sformatf("stream bit %0d", bad), cap[s + bad], exp_q[bad]);
  endtask

  task automatic pulse_init();
    @(negedge clk); init_req = 1'b1; @(negedge clk); init_req = 1'b0;
    chk(init_busy == 1'b1, "R10", "init_busy after init_req", init_busy, 1);
    repeat (8) @(negedge clk);
    chk(init_busy == 1'b0, "R10", "init_busy after init done", init_busy, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(init_busy == 1'b1 && tx_bit == 1'b1 && fifo_ready == 1'b0, "R10", "state in reset",
        {init_busy, tx_bit, fifo_ready}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(init_busy == 1'b1, "R10", "init_busy after reset", init_busy, 1);
    repeat (8) @(negedge clk);
    chk(init_busy == 1'b0, "R10", "init done", init_busy, 0);
  endtask

  task automatic t_strobe();
    int n = 0;
    repeat (400) begin @(negedge clk); if (tx_stb) n++; end
    chk(n == 400 / DIV, "R12", "strobe count", n, 400 / DIV);
  endtask

  task automatic t_crc();
    fb = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    chk(ref_crc() == 16'h906E, "R3", "reference FCS", ref_crc(), 16'h906E);
    start_cap();
    e_clear(); e_byte(8'h7E, 0); e_content(1); e_byte(8'h7E, 0); e_byte(8'hFF, 0); e_byte(8'hFF, 0);
    push_fb(1); wait_bits(exp_q.size() + 16);
    cmp_stream("R1 R3 frame with auto FCS");
  endtask

  task automatic t_stuff();
    fb = '{8'hF8, 8'h1F, 8'hFF, 8'h7E, 8'h3F};
    start_cap();
    e_clear(); e_byte(8'h7E, 0); e_content(1); e_byte(8'h7E, 0); e_byte(8'hFF, 0); e_byte(8'hFF, 0);
    push_fb(1); wait_bits(exp_q.size() + 16);
    cmp_stream("R2 stuffing across bytes");
  endtask

  task automatic t_pair(input logic [2:0] fc, input bit prio, input int nfill, input bit share, input string req);
    cfg_fill_cnt = fc; cfg_prio_off = prio;
    start_cap();
    e_clear();
    fb = '{8'h11, 8'h22};
    e_byte(8'h7E, 0); e_content(1); e_byte(8'h7E, 0);
    push_fb(1);
    for (int i = 0; i < nfill; i++) e_byte(8'hFF, 0);
    if (!share) e_byte(8'h7E, 0);
    fb = '{8'h33};
    e_content(1); e_byte(8'h7E, 0); e_byte(8'hFF, 0); e_byte(8'hFF, 0);
    push_fb(1);
    wait_bits(exp_q.size() + 16);
    cmp_stream(req);
    cfg_fill_cnt = 3'd1; cfg_prio_off = 1'b0;
  endtask

  task automatic t_idle_value();
    int hit = 0;
    cfg_prio_off = 1'b1; cfg_idle_ones = 1'b0;
    wait_bits(16); start_cap(); wait_bits(48);
    for (int o = 0; o < 8; o++) begin
      bit ok = 1'b1;
      for (int i = 0; i < 32; i++) if (cap[o + i] !== ((8'h7E >> (i % 8)) & 1)) ok = 1'b0;
      if (ok) hit = 1;
    end
    chk(hit == 1, "R6", "flag fill with priority disabled", hit, 1);
    cfg_prio_off = 1'b0;
    wait_bits(16); start_cap(); wait_bits(32);
    hit = 1;
    foreach (cap[i]) if (cap[i] !== 1'b1) hit = 0;
    chk(hit == 1 && cap.size() >= 32, "R6", "ones fill when priority enabled", hit, 1);
    cfg_idle_ones = 1'b1;
  endtask

  task automatic t_abort();
    int z, ok;
    fb.delete();
    for (int i = 0; i < 24; i++) fb.push_back(8'h00);
    start_cap();
    push_fb(1);
    wait_bits(80);
    abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
    chk(abort_pend == 1'b1, "R7", "abort_pend set", abort_pend, 1);
    wait_bits(40);
    chk(abort_pend == 1'b0, "R7", "abort_pend cleared", abort_pend, 0);
    chk(fq.size() == 0, "R7", "queue flushed", fq.size(), 0);
    z = -1;
    foreach (cap[i]) if (cap[i] == 1'b0) z = i;
    ok = (z >= 8 && z < 27 * 8 && cap.size() - z > 16) ? 1 : 0;
    if (ok) begin
      for (int i = 1; i <= 7; i++) if (cap[z - i] !== 1'b1) ok = 0;
      for (int i = z + 1; i < cap.size(); i++) if (cap[i] !== 1'b1) ok = 0;
    end
    chk(ok == 1, "R7", "seven ones then fill, frame cut short", z, 0);
  endtask

  task automatic t_underrun();
    fb = '{8'hA5, 8'h5A};
    start_cap();
    e_clear(); e_byte(8'h7E, 0); e_content(0); e_byte(8'h7F, 0); e_byte(8'hFF, 0); e_byte(8'hFF, 0);
    push_fb(0); wait_bits(exp_q.size() + 16);
    cmp_stream("R11 underrun ends frame with abort");
  endtask

  task automatic t_transparent();
    cfg_transparent = 1'b1;
    fb = '{8'h44, 8'h55};
    start_cap();
    e_clear(); e_byte(8'h7E, 0); e_content(1); e_byte(8'h7E, 0); e_byte(8'hFF, 0);
    push_fb(1); wait_bits(exp_q.size() + 16);
    cmp_stream("R8 mode ignored until init");
    pulse_init();
    fb = '{8'h7E, 8'hFF, 8'h00, 8'hA5};
    start_cap();
    e_clear(); foreach (fb[k]) e_byte(fb[k], 0); e_byte(8'hFF, 0); e_byte(8'hFF, 0);
    push_fb(1); wait_bits(exp_q.size() + 16);
    cmp_stream("R8 transparent bytes raw");
    cfg_transparent = 1'b0;
    pulse_init();
  endtask

  task automatic t_manual();
    cfg_manual_fcs = 1'b1;
    pulse_init();
    fb = '{8'h11, 8'h22, 8'hAB, 8'hFC};
    start_cap();
    e_clear(); e_byte(8'h7E, 0); e_content(0); e_byte(8'h7E, 0); e_byte(8'hFF, 0);
    push_fb(1); wait_bits(exp_q.size() + 16);
    cmp_stream("R9 manual FCS from queue");
    cfg_manual_fcs = 1'b0;
    pulse_init();
  endtask

  bit done = 1'b0;
  initial begin
    t_reset();
    t_strobe();
    t_crc();
    t_stuff();
    t_pair(3'd7, 1'b0, 6, 1'b0, "R4 fill count 7 gives six fill bytes");
    t_pair(3'd1, 1'b0, 0, 1'b0, "R4 fill count 1 gives no fill");
    t_pair(3'd0, 1'b0, 0, 1'b0, "R5 fill count 0 gated to 1");
    t_pair(3'd0, 1'b1, 0, 1'b1, "R5 shared flag");
    t_idle_value();
    t_abort();
    t_underrun();
    t_transparent();
    t_manual();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule